// File: doc/BRIEF.md
# Branch Condition Code Evaluator

This block decides whether a conditional branch is taken. It receives a 4-bit condition number together with five arithmetic flags and produces one bit that is high when the selected condition holds. The flags arrive as a 5-bit vector: bit 0 is carry (C), bit 1 is overflow (V), bit 2 is zero (Z), bit 3 is negative (N), bit 4 is the processor-specific P flag.

The evaluation is purely combinational. A single output register stage sits behind it with a valid/ready handshake on each side. A request is accepted on a rising clock edge when `cond_valid` and `cond_ready` are both high. Its result is presented with `res_valid` on the next cycle. The result stays on the outputs until a cycle in which `res_ready` is high. Back-pressure is passed straight upstream. While a result is held and `res_ready` is low, `cond_ready` is low and new requests wait. A result can be taken and a new request accepted on the same edge, so with `res_ready` tied high the block runs one request per cycle.

Top module: `branch_cond_unit`

## Requirements
- R1: Code 0 yields 1 exactly when C (flags bit 0) is 0; code 1 yields 1 exactly when C is 1.
- R2: Code 2 yields 1 exactly when Z (flags bit 2) is 0; code 3 yields 1 exactly when Z is 1.
- R3: Code 4 yields 1 exactly when V (flags bit 1) is 0; code 5 yields 1 exactly when V is 1.
- R4: Code 6 yields 1 exactly when N (flags bit 3) is 0; code 7 yields 1 exactly when N is 1.
- R5: Code 8 yields C OR Z (bits 0, 2); code 9 yields the inverse of code 8.
- R6: Code 10 yields 1 when V (bit 1) equals N (bit 3); code 11 yields 1 when they differ.
- R7: Code 12 yields 1 when V (bit 1) equals N (bit 3) and Z (bit 2) is 0; code 13 yields the inverse of code 12.
- R8: Code 14 yields 1 for every flag value.
- R9: Code 15 yields the P flag (flags bit 4) and ignores all other flags.
- R10: A request accepted on an edge has its result on `res_taken` with `res_valid` high after that edge. With `res_ready` high and no new request, `res_valid` drops after the next edge, so it is a one-cycle pulse.
- R11: While `res_valid` is high and `res_ready` is low, `cond_ready` is low and `res_taken` and `res_valid` hold their values. Raising `res_ready` lets a waiting request be accepted on the same edge that the held result is taken.
- R12: Synchronous active-high reset clears `res_valid` and `res_taken` on the next edge. This includes the case where a result is still held at the time of reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cond_valid | input | 1 | Request present |
| cond_ready | output | 1 | Block can accept a request this cycle |
| cond_code | input | 4 | Condition number 0..15 |
| cond_flags | input | 5 | {P, N, Z, V, C} from bit 4 down to bit 0 |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Consumer takes the result this cycle |
| res_taken | output | 1 | 1 when the condition holds |

## Verification
The conditions that combine flags are the easiest to get wrong. A swapped V/N pairing or a dropped Z term in codes 10 to 13 would still pass the single-flag codes. The bench therefore compares every code against all 32 flag values. Code 15 is driven with every flag except P set, and then with P alone set; a design that tied it to another flag or treated it as never-taken would fail. The handshake is exercised with a result held under back-pressure while a second request waits. A stage that let the second request overwrite the held result, or that lost the request on release, shows the wrong value. A reset issued while a result is held must clear it at once.

// File: rtl/bcu_pkg.sv
package bcu_pkg;

  localparam int CODE_W    = 4;
  localparam int NUM_CODES = 1 << CODE_W;
  localparam int FLAG_W    = 5;

  typedef enum logic [CODE_W-1:0] {
    CC_C_CLR   = 4'd0,
    CC_C_SET   = 4'd1,
    CC_Z_CLR   = 4'd2,
    CC_Z_SET   = 4'd3,
    CC_V_CLR   = 4'd4,
    CC_V_SET   = 4'd5,
    CC_N_CLR   = 4'd6,
    CC_N_SET   = 4'd7,
    CC_ULE     = 4'd8,
    CC_UGT     = 4'd9,
    CC_SGE     = 4'd10,
    CC_SLT     = 4'd11,
    CC_SGT     = 4'd12,
    CC_SLE     = 4'd13,
    CC_ALWAYS  = 4'd14,
    CC_PFLAG   = 4'd15
  } cond_e;

  // Packed so that c lands at bit 0 and p at bit 4.
  typedef struct packed {
    logic p;
    logic n;
    logic z;
    logic v;
    logic c;
  } flags_t;

  function automatic logic cond_holds(input cond_e code, input flags_t f);
    logic res;
    case (code)
      CC_C_CLR:  res = ~f.c;
      CC_C_SET:  res = f.c;
      CC_Z_CLR:  res = ~f.z;
      CC_Z_SET:  res = f.z;
      CC_V_CLR:  res = ~f.v;
      CC_V_SET:  res = f.v;
      CC_N_CLR:  res = ~f.n;
      CC_N_SET:  res = f.n;
      CC_ULE:    res = f.c | f.z;
      CC_UGT:    res = ~(f.c | f.z);
      CC_SGE:    res = ~(f.v ^ f.n);
      CC_SLT:    res = f.v ^ f.n;
      CC_SGT:    res = ~((f.v ^ f.n) | f.z);
      CC_SLE:    res = (f.v ^ f.n) | f.z;
      CC_ALWAYS: res = 1'b1;
      CC_PFLAG:  res = f.p;
      default:   res = 1'b0;
    endcase
    return res;
  endfunction

endpackage

// File: rtl/bcu_cond_vec.sv
// Evaluates every condition in parallel for one flag vector.
module bcu_cond_vec
  import bcu_pkg::*;
#(
  parameter int N = NUM_CODES
) (
  input  flags_t       flags,
  output logic [N-1:0] hits
);

  for (genvar k = 0; k < N; k++) begin : g_cond
    assign hits[k] = cond_holds(cond_e'(k), flags);
  end

endmodule

// File: rtl/bcu_select.sv
// Picks the condition bit named by the code.
module bcu_select
  import bcu_pkg::*;
#(
  parameter int W = CODE_W,
  localparam int N = 1 << W
) (
  input  logic [N-1:0] hits,
  input  logic [W-1:0] code,
  output logic         sel
);

  assign sel = hits[code];

endmodule

// File: rtl/bcu_pipe_reg.sv
// One register slot with valid/ready on both sides.
module bcu_pipe_reg #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         up_valid,
  output logic         up_ready,
  input  logic [W-1:0] up_data,
  output logic         dn_valid,
  input  logic         dn_ready,
  output logic [W-1:0] dn_data
);

  assign up_ready = ~dn_valid | dn_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      dn_valid <= 1'b0;
      dn_data  <= '0;
    end else if (up_ready) begin
      dn_valid <= up_valid;
      if (up_valid) dn_data <= up_data;
    end
  end

endmodule

// File: rtl/branch_cond_unit.sv
module branch_cond_unit
  import bcu_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cond_valid,
  output logic              cond_ready,
  input  logic [CODE_W-1:0] cond_code,
  input  logic [FLAG_W-1:0] cond_flags,
  output logic              res_valid,
  input  logic              res_ready,
  output logic              res_taken
);

  logic [NUM_CODES-1:0] hits;
  logic                 taken_now;

  bcu_cond_vec #(.N(NUM_CODES)) u_vec (
    .flags (flags_t'(cond_flags)),
    .hits  (hits)
  );

  bcu_select #(.W(CODE_W)) u_sel (
    .hits (hits),
    .code (cond_code),
    .sel  (taken_now)
  );

  bcu_pipe_reg #(.W(1)) u_out (
    .clk      (clk),
    .rst      (rst),
    .up_valid (cond_valid),
    .up_ready (cond_ready),
    .up_data  (taken_now),
    .dn_valid (res_valid),
    .dn_ready (res_ready),
    .dn_data  (res_taken)
  );

endmodule

// File: rtl/branch_cond_unit_chk.sv
module branch_cond_unit_chk (
  input logic       clk,
  input logic       rst,
  input logic       cond_valid,
  input logic       cond_ready,
  input logic [3:0] cond_code,
  input logic [4:0] cond_flags,
  input logic       res_valid,
  input logic       res_ready,
  input logic       res_taken
);

  logic accept;
  assign accept = cond_valid & cond_ready;

  assert_result_follows_R10: assert property (@(posedge clk) disable iff (rst)
    accept |=> res_valid);

  assert_pulse_drains_R10: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_ready && !accept) |=> !res_valid);

  assert_hold_stable_R11: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_taken)));

  assert_stall_upstream_R11: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_ready) |-> !cond_ready);

  assert_always_taken_R8: assert property (@(posedge clk) disable iff (rst)
    (accept && cond_code == 4'd14) |=> res_taken);

  assert_pflag_only_R9: assert property (@(posedge clk) disable iff (rst)
    (accept && cond_code == 4'd15) |=> (res_taken == $past(cond_flags[4])));

  assert_reset_clears_R12: assert property (@(posedge clk)
    rst |=> (!res_valid && !res_taken));

endmodule

bind branch_cond_unit branch_cond_unit_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .cond_valid (cond_valid),
  .cond_ready (cond_ready),
  .cond_code  (cond_code),
  .cond_flags (cond_flags),
  .res_valid  (res_valid),
  .res_ready  (res_ready),
  .res_taken  (res_taken)
);

// File: tb/branch_cond_unit_tb.sv
`timescale 1ns/1ps
module branch_cond_unit_tb;

  logic       clk = 1'b0;
  logic       rst;
  logic       cond_valid;
  logic       cond_ready;
  logic [3:0] cond_code;
  logic [4:0] cond_flags;
  logic       res_valid;
  logic       res_ready;
  logic       res_taken;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  branch_cond_unit u_dut (
    .clk        (clk),
    .rst        (rst),
    .cond_valid (cond_valid),
    .cond_ready (cond_ready),
    .cond_code  (cond_code),
    .cond_flags (cond_flags),
    .res_valid  (res_valid),
    .res_ready  (res_ready),
    .res_taken  (res_taken)
  );

  // Vector format: {code[3:0], flags {P,N,Z,V,C}[4:0], expected}
  localparam int NVEC = 15;
  localparam logic [9:0] VEC [NVEC] = '{
    {4'd0,  5'b00000, 1'b1},  // R1
    {4'd1,  5'b00001, 1'b1},  // R1
    {4'd2,  5'b00100, 1'b0},  // R2
    {4'd3,  5'b00100, 1'b1},  // R2
    {4'd4,  5'b00010, 1'b0},  // R3
    {4'd7,  5'b01000, 1'b1},  // R4
    {4'd8,  5'b00100, 1'b1},  // R5
    {4'd9,  5'b00000, 1'b1},  // R5
    {4'd10, 5'b01010, 1'b1},  // R6
    {4'd11, 5'b01000, 1'b1},  // R6
    {4'd12, 5'b01110, 1'b0},  // R7
    {4'd13, 5'b00000, 1'b0},  // R7
    {4'd14, 5'b00000, 1'b1},  // R8
    {4'd15, 5'b10000, 1'b1},  // R9
    {4'd15, 5'b01111, 1'b0}   // R9
  };

  function automatic logic expect_bit(input logic [3:0] code, input logic [4:0] f);
    logic c, v, z, n, p;
    c = f[0]; v = f[1]; z = f[2]; n = f[3]; p = f[4];
    case (code)
      4'd0:  return !c;
      4'd1:  return c;
      4'd2:  return !z;
      4'd3:  return z;
      4'd4:  return !v;
      4'd5:  return v;
      4'd6:  return !n;
      4'd7:  return n;
      4'd8:  return c || z;
      4'd9:  return !c && !z;
      4'd10: return v == n;
      4'd11: return v != n;
      4'd12: return (v == n) && !z;
      4'd13: return (v != n) || z;
      4'd14: return 1'b1;
      default: return p;
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] code);
    case (code)
      4'd0, 4'd1:   return "R1";
      4'd2, 4'd3:   return "R2";
      4'd4, 4'd5:   return "R3";
      4'd6, 4'd7:   return "R4";
      4'd8, 4'd9:   return "R5";
      4'd10, 4'd11: return "R6";
      4'd12, 4'd13: return "R7";
      4'd14:        return "R8";
      default:      return "R9";
    endcase
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Presents one request and returns at the following falling edge,
  // after the accepting rising edge.
  task automatic send(input logic [3:0] c, input logic [4:0] f);
    @(negedge clk);
    cond_valid = 1'b1;
    cond_code  = c;
    cond_flags = f;
    @(negedge clk);
    cond_valid = 1'b0;
  endtask

  initial begin
    rst = 1'b1;
    cond_valid = 1'b0;
    cond_code = '0;
    cond_flags = '0;
    res_ready = 1'b1;
    repeat (3) @(negedge clk);
    // R12: reset state
    check("R12", "valid after reset", {7'd0, res_valid}, 8'd0);
    check("R12", "taken after reset", {7'd0, res_taken}, 8'd0);
    rst = 1'b0;

    // Directed vectors
    for (int i = 0; i < NVEC; i++) begin
      send(VEC[i][9:6], VEC[i][5:1]);
      check(tag_of(VEC[i][9:6]), "vector", {6'd0, res_valid, res_taken},
            {6'd0, 1'b1, VEC[i][0]});
    end

    // Every code against every flag pattern
    for (int c = 0; c < 16; c++) begin
      for (int f = 0; f < 32; f++) begin
        send(4'(c), 5'(f));
        check(tag_of(4'(c)), "sweep", {6'd0, res_valid, res_taken},
              {6'd0, 1'b1, expect_bit(4'(c), 5'(f))});
      end
    end

    // R10: valid is a single-cycle pulse with res_ready high
    send(4'd14, 5'b0);
    check("R10", "valid after accept", {7'd0, res_valid}, 8'd1);
    @(negedge clk);
    check("R10", "valid drops after take", {7'd0, res_valid}, 8'd0);

    // R11: back-pressure holds the result and stalls the input
    res_ready = 1'b0;
    send(4'd14, 5'b0);
    cond_valid = 1'b1;
    cond_code  = 4'd15;
    cond_flags = 5'b01111;
    repeat (3) @(negedge clk);
    check("R11", "input stalled", {7'd0, cond_ready}, 8'd0);
    check("R11", "held result", {6'd0, res_valid, res_taken}, 8'b11);
    res_ready = 1'b1;
    @(negedge clk);
    cond_valid = 1'b0;
    check("R11", "waiting request result", {6'd0, res_valid, res_taken}, 8'b10);
    @(negedge clk);
    check("R10", "drained", {7'd0, res_valid}, 8'd0);

    // R12: reset while a result is held
    res_ready = 1'b0;
    send(4'd14, 5'b0);
    rst = 1'b1;
    @(negedge clk);
    check("R12", "reset clears held", {6'd0, res_valid, res_taken}, 8'd0);
    rst = 1'b0;
    res_ready = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

endmodule